// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Power-Up Hold-Off

The block collects interrupt causes from several places and folds them onto one interrupt line. Second-level source groups each keep a 32-bit pending value and a mask. One group holds USB core events, one holds DMA completions, and one holds GPIO events. Software sets and clears pending bits through separate write addresses.

The unmasked pending bits of the USB group are reduced into two summary bits of the 32-bit top-level pending value, one for each 16-bit half. The DMA group is reduced into one summary bit. Level inputs from the core drive the low top-level bits directly. The GPIO group is stored and can be read back, but it never reaches the top level.

A control register selects the line polarity. In one setting the line is asserted while an unmasked cause is pending. In the other it is asserted while none is pending. A settle gate holds the line low after each power-up until a fixed number of cycles has passed. The line comes from a flop.

Top module: `irq_hier_agg`

## Requirements
- R1: After reset the top-level mask reads 0xFFFFFFFF. Every pending value, every second-level mask and the control register read 0, and `irq_o` is 0.
- R2: A write to a group's set address ORs the data into its pending value. A write to its clear address clears every pending bit where the data bit is 1.
- R3: Address map, in bytes. Group g (top=0, USB=1, DMA=2, GPIO=3) sits at g*0x10. The pending value is at +0x0, set at +0x4, clear at +0x8 and mask at +0xC. Control is at 0x40. Reading the pending, set or clear address returns the pending value. Reading the mask address returns the mask, and control reads back as written.
- R4: Top-level bit 9 is 1 exactly when any of USB pending bits 15:0 is set and unmasked.
- R5: Top-level bit 8 is 1 exactly when any of USB pending bits 31:16 is set and unmasked.
- R6: Top-level bit 24 is 1 exactly when any DMA pending bit is set and unmasked.
- R7: Top-level set and clear writes have no visible effect on bits 8, 9 and 24.
- R8: When control bit 17 is 1, `irq_o` is 1 while the gate is open and some top-level bit is pending and unmasked. When bit 17 is 0, `irq_o` is 1 while the gate is open and no unmasked top-level bit is pending.
- R9: `irq_o` reflects a register write one clock after the edge that takes the write.
- R10: On a rising edge of `pwr_on` the gate closes. It opens SETTLE_CYC clocks after the edge that sees the rise, if power stayed on. `pwr_on` low closes the gate and abandons the count, so a later rise starts the count again.
- R11: When core event input i changes level, top-level bit i takes the new level. While the input is steady, software set and clear act on that bit normally.
- R12: GPIO group writes change only the GPIO read-back and never affect `irq_o`.
- R13: Unmapped addresses read as 0, and writes to them change no register. Unmapped addresses are those with nonzero bits 1:0, bits above 6 set, or group 4 with an offset other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_evt | input | EVT_W | Level event inputs driving top-level bits 0 upward |
| pwr_on | input | 1 | Power state; a rise starts the settle period |
| irq_o | output | 1 | Registered interrupt line |

## Verification
USB pending bits are placed in each half separately, then masked one half at a time. This separates the TX summary from the RX summary and shows that the mask is applied before the reduction. Writes to the top-level set and clear addresses aimed at the summary positions confirm that those bits stay derived. Both polarities are tried with nothing pending, with an unmasked cause pending and with the cause masked, so an inverted or ignored polarity bit is caught. Power is raised cleanly and also with a short dropout, and the gate is checked at the exact opening cycle, which exposes an off-by-one count or a count that is not restarted.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  localparam logic [2:0] GRP_TOP  = 3'd0;
  localparam logic [2:0] GRP_USB  = 3'd1;
  localparam logic [2:0] GRP_DMA  = 3'd2;
  localparam logic [2:0] GRP_GPIO = 3'd3;
  localparam logic [2:0] GRP_CTRL = 3'd4;
  localparam int NUM_GRP = 4;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_SET  = 2'd1;
  localparam logic [1:0] REG_CLR  = 2'd2;
  localparam logic [1:0] REG_MASK = 2'd3;

  localparam int BIT_USB_RX = 8;
  localparam int BIT_USB_TX = 9;
  localparam int BIT_DMA    = 24;
  localparam int BIT_POL    = 17;

  localparam logic [DATA_W-1:0] SUMMARY_BITS =
    (DATA_W'(1) << BIT_USB_RX) | (DATA_W'(1) << BIT_USB_TX) | (DATA_W'(1) << BIT_DMA);

  typedef struct packed {
    logic       hit;
    logic [2:0] grp;
    logic [1:0] rsel;
  } bus_dec_t;

  function automatic bus_dec_t bus_decode(input logic [15:0] a);
    bus_dec_t d;
    d.grp  = a[6:4];
    d.rsel = a[3:2];
    d.hit  = (a[1:0] == 2'b00) && (a[15:7] == '0) &&
             ((d.grp < GRP_CTRL) || ((d.grp == GRP_CTRL) && (d.rsel == REG_SRC)));
    return d;
  endfunction

  function automatic logic usb_tx_sum(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] m);
    return |(p[HALF_W-1:0] & ~m[HALF_W-1:0]);
  endfunction

  function automatic logic usb_rx_sum(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] m);
    return |(p[DATA_W-1:HALF_W] & ~m[DATA_W-1:HALF_W]);
  endfunction

  function automatic logic any_sum(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] m);
    return |(p & ~m);
  endfunction

  function automatic logic line_level(input logic pol, input logic active, input logic ready);
    return ready & (pol ? active : ~active);
  endfunction
endpackage

// File: rtl/irq_src_group.sv
module irq_src_group
  import irq_agg_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  output logic [DATA_W-1:0] pend_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] pend_q, mask_q, sw_next, pend_next;

  always_comb begin
    sw_next = pend_q;
    if (wr_set) sw_next = sw_next | wdata;
    if (wr_clr) sw_next = sw_next & ~wdata;
    pend_next = (sw_next | hw_set) & ~hw_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= pend_next;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_evt_follow.sv
module irq_evt_follow
  import irq_agg_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  output logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] hw_clr
);
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] evt_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_in;
  end

  assign evt_chg = evt_in ^ evt_q;
  assign hw_set  = DATA_W'(evt_chg & evt_in);
  assign hw_clr  = DATA_W'(evt_chg & ~evt_in);
endmodule

// File: rtl/irq_pwr_gate.sv
module irq_pwr_gate #(
  parameter int SETTLE_CYC = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic ready_o,
  output logic rise_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

  logic          pwr_q, run_q, ready_q;
  logic [CW-1:0] cnt_q;

  assign rise_o = pwr_on & ~pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      run_q   <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pwr_q <= pwr_on;
      if (!pwr_on) begin
        run_q   <= 1'b0;
        ready_q <= 1'b0;
      end else if (rise_o) begin
        run_q   <= 1'b1;
        ready_q <= 1'b0;
        cnt_q   <= LOAD;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q   <= 1'b0;
          ready_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/irq_line_out.sv
module irq_line_out
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic active,
  input  logic ready,
  output logic line_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_o <= 1'b0;
    else        line_o <= line_level(pol, active, ready);
  end
endmodule

// File: rtl/irq_hier_agg.sv
module irq_hier_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int EVT_W      = 8,
  parameter int SETTLE_CYC = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EVT_W-1:0]  core_evt,
  input  logic              pwr_on,
  output logic              irq_o
);
  bus_dec_t dec;
  logic     bus_hit;
  logic [NUM_GRP-1:0] wr_set, wr_clr, wr_mask;
  logic [DATA_W-1:0]  grp_pend [NUM_GRP];
  logic [DATA_W-1:0]  grp_mask [NUM_GRP];
  logic [DATA_W-1:0]  evt_set, evt_clr;
  logic [DATA_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  top_view, top_mask, usb_pend, usb_mask, dma_pend, dma_mask;
  logic [DATA_W-1:0]  gpio_pend, gpio_mask;
  logic               wr_usb_set, wr_usb_clr, wr_ctrl;
  logic               pol, top_active, gate_ready, pwr_rise;
  logic               sum_tx, sum_rx, sum_dma;
  logic [8*DATA_W-1:0] cfg_state;

  assign dec     = bus_decode(16'(bus_addr));
  assign bus_hit = dec.hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_strobe
    assign wr_set[g]  = bus_wr && bus_hit && (dec.grp == 3'(g)) && (dec.rsel == REG_SET);
    assign wr_clr[g]  = bus_wr && bus_hit && (dec.grp == 3'(g)) && (dec.rsel == REG_CLR);
    assign wr_mask[g] = bus_wr && bus_hit && (dec.grp == 3'(g)) && (dec.rsel == REG_MASK);
  end
  assign wr_ctrl    = bus_wr && bus_hit && (dec.grp == GRP_CTRL);
  assign wr_usb_set = wr_set[GRP_USB];
  assign wr_usb_clr = wr_clr[GRP_USB];

  irq_evt_follow #(.EVT_W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_in(core_evt), .hw_set(evt_set), .hw_clr(evt_clr)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == 0) begin : g_top
      irq_src_group #(.MASK_RST('1)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .wr_set(wr_set[g]), .wr_clr(wr_clr[g]), .wr_mask(wr_mask[g]),
        .wdata(bus_wdata), .hw_set(evt_set), .hw_clr(evt_clr),
        .pend_o(grp_pend[g]), .mask_o(grp_mask[g])
      );
    end else begin : g_sub
      irq_src_group #(.MASK_RST('0)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .wr_set(wr_set[g]), .wr_clr(wr_clr[g]), .wr_mask(wr_mask[g]),
        .wdata(bus_wdata), .hw_set('0), .hw_clr('0),
        .pend_o(grp_pend[g]), .mask_o(grp_mask[g])
      );
    end
  end

  assign top_mask  = grp_mask[GRP_TOP];
  assign usb_pend  = grp_pend[GRP_USB];
  assign usb_mask  = grp_mask[GRP_USB];
  assign dma_pend  = grp_pend[GRP_DMA];
  assign dma_mask  = grp_mask[GRP_DMA];
  assign gpio_pend = grp_pend[GRP_GPIO];
  assign gpio_mask = grp_mask[GRP_GPIO];

  assign sum_tx  = usb_tx_sum(usb_pend, usb_mask);
  assign sum_rx  = usb_rx_sum(usb_pend, usb_mask);
  assign sum_dma = any_sum(dma_pend, dma_mask);

  always_comb begin
    top_view             = grp_pend[GRP_TOP] & ~SUMMARY_BITS;
    top_view[BIT_USB_TX] = sum_tx;
    top_view[BIT_USB_RX] = sum_rx;
    top_view[BIT_DMA]    = sum_dma;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end

  assign pol        = ctrl_q[BIT_POL];
  assign top_active = any_sum(top_view, top_mask);

  irq_pwr_gate #(.SETTLE_CYC(SETTLE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ready_o(gate_ready), .rise_o(pwr_rise)
  );

  irq_line_out u_line (
    .clk(clk), .rst_n(rst_n), .pol(pol), .active(top_active), .ready(gate_ready), .line_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_hit) begin
      if (dec.grp == GRP_CTRL) begin
        bus_rdata = ctrl_q;
      end else begin
        case (dec.grp)
          GRP_TOP:  bus_rdata = (dec.rsel == REG_MASK) ? top_mask  : top_view;
          GRP_USB:  bus_rdata = (dec.rsel == REG_MASK) ? usb_mask  : usb_pend;
          GRP_DMA:  bus_rdata = (dec.rsel == REG_MASK) ? dma_mask  : dma_pend;
          default:  bus_rdata = (dec.rsel == REG_MASK) ? gpio_mask : gpio_pend;
        endcase
      end
    end
  end

  assign cfg_state = {usb_pend, usb_mask, dma_pend, dma_mask, gpio_pend, gpio_mask, top_mask, ctrl_q};
endmodule

// File: rtl/irq_hier_agg_chk.sv
module irq_hier_agg_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic         bus_hit,
  input logic [31:0]  bus_wdata,
  input logic         wr_usb_set,
  input logic         wr_usb_clr,
  input logic [31:0]  usb_pend,
  input logic [31:0]  usb_mask,
  input logic [31:0]  top_view,
  input logic [31:0]  top_mask,
  input logic         pol,
  input logic         gate_ready,
  input logic         pwr_rise,
  input logic         pwr_on,
  input logic         irq_o,
  input logic [255:0] cfg_state
);
  a_r2_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_usb_clr && bus_wdata == 32'hFFFF_FFFF) |=> (usb_pend == 32'h0));

  a_r4_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_usb_set && ((bus_wdata[15:0] & ~usb_mask[15:0]) != 16'h0)) |=> top_view[9]);

  a_r5_rx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_usb_set && ((bus_wdata[31:16] & ~usb_mask[31:16]) != 16'h0)) |=> top_view[8]);

  a_r8_pol_high: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ready && pol && ((top_view & ~top_mask) != 32'h0)) |=> irq_o);

  a_r8_pol_low: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ready && !pol && ((top_view & ~top_mask) == 32'h0)) |=> irq_o);

  a_r10_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ready |=> !irq_o);

  a_r10_rise_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rise |=> !gate_ready);

  a_r10_off_closes: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !gate_ready);

  a_r13_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_hit) |=> $stable(cfg_state));
endmodule

bind irq_hier_agg irq_hier_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_hit(bus_hit), .bus_wdata(bus_wdata),
  .wr_usb_set(wr_usb_set), .wr_usb_clr(wr_usb_clr), .usb_pend(usb_pend), .usb_mask(usb_mask),
  .top_view(top_view), .top_mask(top_mask), .pol(pol), .gate_ready(gate_ready),
  .pwr_rise(pwr_rise), .pwr_on(pwr_on), .irq_o(irq_o), .cfg_state(cfg_state)
);

// File: tb/test_irq_hier_agg.sv
`timescale 1ns/1ps
module test_irq_hier_agg;
  localparam int S = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  core_evt = '0;
  logic        pwr_on = 1'b0;
  logic        irq_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  irq_hier_agg #(.ADDR_W(8), .EVT_W(8), .SETTLE_CYC(S)) i_irq_hier_agg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_evt(core_evt), .pwr_on(pwr_on), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 top mask", 8'h0C, 32'hFFFF_FFFF);
    rdchk("R1 top pend", 8'h00, 32'h0);
    rdchk("R1 usb pend", 8'h10, 32'h0);
    rdchk("R1 usb mask", 8'h1C, 32'h0);
    rdchk("R1 dma mask", 8'h2C, 32'h0);
    rdchk("R1 ctrl", 8'h40, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_set_clr;
    wr(8'h14, 32'h0000_00F0);
    wr(8'h14, 32'h0F00_0000);
    rdchk("R2 set ORs", 8'h10, 32'h0F00_00F0);
    rdchk("R3 read at set", 8'h14, 32'h0F00_00F0);
    rdchk("R3 read at clr", 8'h18, 32'h0F00_00F0);
    wr(8'h18, 32'h0300_0030);
    rdchk("R2 clear ones", 8'h10, 32'h0C00_00C0);
    wr(8'h1C, 32'hA5A5_0000);
    rdchk("R3 mask read", 8'h1C, 32'hA5A5_0000);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0);
    rdchk("R2 clear all", 8'h10, 32'h0);
  endtask

  task automatic t_summary;
    logic [31:0] d;
    wr(8'h14, 32'h0000_0001);
    rd(8'h00, d); chk("R4 tx sum", d & 32'h0100_0300, 32'h0000_0200);
    wr(8'h14, 32'h0001_0000);
    rd(8'h00, d); chk("R5 rx sum", d & 32'h0100_0300, 32'h0000_0300);
    wr(8'h1C, 32'h0000_FFFF);
    rd(8'h00, d); chk("R4 R5 masked low", d & 32'h0100_0300, 32'h0000_0100);
    wr(8'h08, 32'h0100_0300);
    rd(8'h00, d); chk("R7 clr no effect", d & 32'h0100_0300, 32'h0000_0100);
    wr(8'h24, 32'h0000_0004);
    rd(8'h00, d); chk("R6 dma sum", d & 32'h0100_0000, 32'h0100_0000);
    wr(8'h2C, 32'h0000_0004);
    rd(8'h00, d); chk("R6 dma masked", d & 32'h0100_0000, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2C, 32'h0);
    wr(8'h04, 32'h0100_0300);
    rd(8'h00, d); chk("R7 set no effect", d & 32'h0100_0300, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    @(negedge clk); core_evt = 8'h08;
    @(negedge clk); rd(8'h00, d); chk("R11 rise sets", d & 32'hFF, 32'h08);
    wr(8'h08, 32'h0000_0008);
    @(negedge clk); rd(8'h00, d); chk("R11 sw clear while steady", d & 32'hFF, 32'h0);
    core_evt = 8'h00;
    @(negedge clk); rd(8'h00, d); chk("R11 fall", d & 32'hFF, 32'h0);
    core_evt = 8'h08;
    @(negedge clk); rd(8'h00, d); chk("R11 rise again", d & 32'hFF, 32'h08);
    core_evt = 8'h00;
    @(negedge clk); rd(8'h00, d); chk("R11 fall clears", d & 32'hFF, 32'h0);
  endtask

  task automatic t_gpio_unmapped;
    wr(8'h34, 32'h0000_FFFF);
    rdchk("R12 gpio read", 8'h30, 32'h0000_FFFF);
    wr(8'h44, 32'h1234_5678);
    wr(8'h42, 32'hFFFF_FFFF);
    wr(8'h9C, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    rdchk("R13 read 0x44", 8'h44, 32'h0);
    rdchk("R13 read 0x9C", 8'h9C, 32'h0);
    rdchk("R13 read 0x41", 8'h41, 32'h0);
    rdchk("R13 ctrl kept", 8'h40, 32'h0);
    rdchk("R13 usb mask kept", 8'h1C, 32'h0);
  endtask

  task automatic t_power;
    wr(8'h40, 32'h0002_0000);
    rdchk("R3 ctrl read", 8'h40, 32'h0002_0000);
    wr(8'h0C, 32'hFFFF_FFFE);
    wr(8'h04, 32'h0000_0001);
    @(negedge clk); pwr_on = 1'b1;
    repeat (S + 1) @(negedge clk);
    chk("R10 gate still closed", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 gate opens", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_polarity;
    wr(8'h08, 32'h0000_0001);
    chk("R9 one cycle latency", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R8 high pol none pending", {31'h0, irq_o}, 32'h0);
    wr(8'h0C, 32'h0);
    @(negedge clk);
    chk("R12 gpio not forwarded", {31'h0, irq_o}, 32'h0);
    wr(8'h40, 32'h0);
    @(negedge clk);
    chk("R8 low pol none pending", {31'h0, irq_o}, 32'h1);
    wr(8'h04, 32'h0000_0020);
    @(negedge clk);
    chk("R8 low pol pending", {31'h0, irq_o}, 32'h0);
    wr(8'h0C, 32'h0000_0020);
    @(negedge clk);
    chk("R8 low pol masked", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_power_cycle;
    @(negedge clk); pwr_on = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 power off closes", {31'h0, irq_o}, 32'h0);
    pwr_on = 1'b1;
    repeat (4) @(negedge clk);
    pwr_on = 1'b0;
    @(negedge clk);
    pwr_on = 1'b1;
    repeat (S + 1) @(negedge clk);
    chk("R10 restart closed", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 restart opens", {31'h0, irq_o}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clr();
    t_summary();
    t_events();
    t_gpio_unmapped();
    t_power();
    t_polarity();
    t_power_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule